// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This peripheral supervises software with two timeout stages in a row. After software sets the enable bit, a shared prescaler divides the input clock into ticks of 2^(BASE_EXP+prescale) cycles. The first stage counts a programmable number of ticks and then raises a pre-timeout interrupt. The second stage then counts its own programmable number of ticks and ends in a one-cycle reset request. A two-bit code that names the kind of reset wanted comes with the request. Software keeps the timer away from both deadlines by writing a kick to the counter register, which sends it back to the start of the first stage.

Software reaches the block through a flat 32-bit register bus with three words: kick at byte offset 0x0, interrupt status at 0x4 and control at 0x8. Reads are combinational. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

A four-state machine sequences the block:
- **IDLE**: the counters are held at zero. IDLE goes to PH1 when enable is set.
- **PH1**: the first stage. PH1 returns to IDLE when enable is cleared. It stays in PH1 with its counts reset on a kick. It goes to PH2 on its final tick and sets the stage-one flag.
- **PH2**: the second stage. Clearing enable has no effect here. A kick sends it back to PH1. Its final tick takes it to FIRE and sets the stage-two flag.
- **FIRE**: lasts one cycle with the reset request high, then returns to IDLE.

Top module: `wdt_twophase`

## Requirements
- R1: After reset, the control word reads 0x0000_0001 (disabled, CPU-reset mode, all other fields zero), the status word reads 0, and `irq_pre`, `rst_req` and `rst_kind` are low.
- R2: A tick lasts 2^(BASE_EXP+PRE) clock cycles. PRE is control bits 30:29 and ENABLE is bit 31. Take E as the edge that writes ENABLE=1. The stage-one flag (status bit 31) is set at edge E + 1 + tick*(PH1+1), where PH1 is control bits 26:22.
- R3: The second stage starts when the first ends. After tick*(PH2+1) more edges, where PH2 is control bits 19:15, `rst_req` is high for exactly one cycle and the stage-two flag (status bit 30) is set.
- R4: During the `rst_req` cycle, `rst_kind` equals the mode field (control bits 1:0: 0 whole-chip, 1 CPU, 2 software). At all other times it is 0.
- R5: A write to offset 0x0 with bit 31 set, in PH1 or PH2, restarts the first stage. The stage-one flag is then due tick*(PH1+1) edges after the kick edge. A write to 0x0 with bit 31 clear has no effect.
- R6: Clearing ENABLE before the first stage ends stops the timer and zeroes both counters. Setting ENABLE again starts a full first stage.
- R7: Once the first stage has ended, clearing ENABLE does not stop the timer. The reset request still comes at the time given in R3.
- R8: Writing 1 to a status bit (bit 31 or bit 30 at offset 0x4) clears that flag. Writing 0 leaves it unchanged.
- R9: Control bits 28:27, 21:20 and 14:2 always read as zero. Offset 0x0 and unmapped offsets read as zero.
- R10: `irq_pre` is high exactly while the stage-one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_pre | output | 1 | Pre-timeout interrupt, level of the stage-one flag |
| rst_req | output | 1 | One-cycle reset request at the end of stage two |
| rst_kind | output | 2 | Reset kind, valid while rst_req is high |

## Verification
Stage-one expiry is due 1 + tick*(PH1+1) edges after the enabling write edge. The extra edge is the IDLE-to-PH1 step. The reset pulse follows tick*(PH2+1) edges after that, and after a kick the whole interval is counted from the kick edge. The bench counts rising edges from each write and samples ports and read data at the following falling edge, so it knows exactly which edge an output changed on. Status and control changes show on the combinational read port in the cycle after the write edge, and the pulse is checked high for one sample and low for the next.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 2;
    localparam int PH_W   = 5;
    localparam int MODE_W = 2;

    localparam logic [ADDR_W-1:0] OFS_KICK = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h8;

    localparam logic [MODE_W-1:0] KIND_CHIP = 2'd0;
    localparam logic [MODE_W-1:0] KIND_CPU  = 2'd1;
    localparam logic [MODE_W-1:0] KIND_SOFT = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH1  = 2'd1,
        ST_PH2  = 2'd2,
        ST_FIRE = 2'd3
    } wdt_state_e;

    typedef struct packed {
        logic              en;
        logic [PRE_W-1:0]  pre;
        logic [PH_W-1:0]   ph1;
        logic [PH_W-1:0]   ph2;
        logic [MODE_W-1:0] mode;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_RESET = '{
        en:   1'b0,
        pre:  '0,
        ph1:  '0,
        ph2:  '0,
        mode: KIND_CPU
    };

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int BASE_EXP = 25,
    parameter int PRE_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    // widest tick is 2^(BASE_EXP + 2^PRE_W - 1) cycles
    localparam int CNT_W = BASE_EXP + (2 ** PRE_W) - 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = (ONE << (BASE_EXP + int'(pre))) - ONE;
    end

    // >= keeps the period bounded if PRE shrinks mid-count
    assign tick = run && (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/wdt_phase_fsm.sv
module wdt_phase_fsm
    import wdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            kick,
    input  logic            tick,
    input  logic [PH_W-1:0] ph1,
    input  logic [PH_W-1:0] ph2,
    output wdt_state_e      state,
    output logic [PH_W-1:0] tcnt,
    output logic            hit1,
    output logic            hit2,
    output logic            run,
    output logic            clr_tick,
    output logic            fire
);
    wdt_state_e      state_nxt;
    logic [PH_W-1:0] tcnt_nxt;

    // next-state and event logic
    always_comb begin
        state_nxt = state;
        tcnt_nxt  = tcnt;
        hit1      = 1'b0;
        hit2      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                tcnt_nxt = '0;
                if (en) begin
                    state_nxt = ST_PH1;
                end
            end
            ST_PH1: begin
                if (!en) begin
                    state_nxt = ST_IDLE;
                    tcnt_nxt  = '0;
                end else if (kick) begin
                    tcnt_nxt = '0;
                end else if (tick) begin
                    if (tcnt >= ph1) begin
                        state_nxt = ST_PH2;
                        tcnt_nxt  = '0;
                        hit1      = 1'b1;
                    end else begin
                        tcnt_nxt = tcnt + 1'b1;
                    end
                end
            end
            ST_PH2: begin
                if (kick) begin
                    state_nxt = ST_PH1;
                    tcnt_nxt  = '0;
                end else if (tick) begin
                    if (tcnt >= ph2) begin
                        state_nxt = ST_FIRE;
                        tcnt_nxt  = '0;
                        hit2      = 1'b1;
                    end else begin
                        tcnt_nxt = tcnt + 1'b1;
                    end
                end
            end
            ST_FIRE: begin
                state_nxt = ST_IDLE;
                tcnt_nxt  = '0;
            end
            default: begin
                state_nxt = ST_IDLE;
                tcnt_nxt  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_nxt;
            tcnt  <= tcnt_nxt;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        run      = (state == ST_PH1) || (state == ST_PH2);
        clr_tick = kick || ((state == ST_PH1) && !en);
        fire     = (state == ST_FIRE);
    end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hit1,
    input  logic              hit2,
    output wdt_cfg_t          cfg,
    output logic              kick,
    output logic              flag1,
    output logic              flag2,
    output logic [DATA_W-1:0] bus_rdata
);
    logic we_kick, we_stat, we_ctrl;
    logic unused_wdata;

    assign we_kick = bus_sel && bus_wr && (bus_addr == OFS_KICK);
    assign we_stat = bus_sel && bus_wr && (bus_addr == OFS_STAT);
    assign we_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign kick    = we_kick && bus_wdata[31];

    assign unused_wdata = ^{bus_wdata[28:27], bus_wdata[21:20], bus_wdata[14:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (we_ctrl) begin
            cfg.en   <= bus_wdata[31];
            cfg.pre  <= bus_wdata[30:29];
            cfg.ph1  <= bus_wdata[26:22];
            cfg.ph2  <= bus_wdata[19:15];
            cfg.mode <= bus_wdata[1:0];
        end
    end

    // a new expiry wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag1 <= 1'b0;
            flag2 <= 1'b0;
        end else begin
            flag1 <= hit1 || (flag1 && !(we_stat && bus_wdata[31]));
            flag2 <= hit2 || (flag2 && !(we_stat && bus_wdata[30]));
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_STAT: bus_rdata = {flag1, flag2, 30'd0};
            OFS_CTRL: bus_rdata = {cfg.en, cfg.pre, 2'b00, cfg.ph1, 2'b00,
                                   cfg.ph2, 13'd0, cfg.mode};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_twophase.sv
module wdt_twophase
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pre,
    output logic              rst_req,
    output logic [MODE_W-1:0] rst_kind
);
    wdt_cfg_t        cfg;
    logic            cfg_en;
    logic            kick;
    logic            tick;
    logic            run;
    logic            clr_tick;
    logic            hit1, hit2;
    logic            flag1, flag2;
    logic            fire;
    wdt_state_e      fsm_state;
    logic [PH_W-1:0] phase_cnt;

    assign cfg_en = cfg.en;

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit1      (hit1),
        .hit2      (hit2),
        .cfg       (cfg),
        .kick      (kick),
        .flag1     (flag1),
        .flag2     (flag2),
        .bus_rdata (bus_rdata)
    );

    wdt_tick_gen #(
        .BASE_EXP (BASE_EXP),
        .PRE_W    (PRE_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (clr_tick),
        .pre   (cfg.pre),
        .tick  (tick)
    );

    wdt_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .kick     (kick),
        .tick     (tick),
        .ph1      (cfg.ph1),
        .ph2      (cfg.ph2),
        .state    (fsm_state),
        .tcnt     (phase_cnt),
        .hit1     (hit1),
        .hit2     (hit2),
        .run      (run),
        .clr_tick (clr_tick),
        .fire     (fire)
    );

    assign irq_pre  = flag1;
    assign rst_req  = fire;
    assign rst_kind = fire ? cfg.mode : '0;

    logic unused_flag2;
    assign unused_flag2 = flag2;

endmodule

// File: rtl/wdt_twophase_chk.sv
module wdt_twophase_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdata_msb,
    input logic              irq_pre,
    input logic              rst_req,
    input logic [MODE_W-1:0] rst_kind,
    input wdt_state_e        st,
    input logic              en,
    input logic              kick,
    input logic [PH_W-1:0]   tcnt
);
    // R3: the reset request never lasts more than one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4: the kind code stays quiet outside the request
    a_r4_kind_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> (rst_kind == 2'b00));

    // R5: a kick puts the machine at the start of stage one
    a_r5_kick_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && ((st == ST_PH2) || ((st == ST_PH1) && en)))
        |=> ((st == ST_PH1) && (tcnt == '0)));

    // R6: clearing enable during stage one stops the timer
    a_r6_stop_in_ph1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PH1) && !en) |=> (st == ST_IDLE));

    // R7: stage two cannot be left by disabling
    a_r7_no_stop_in_ph2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PH2) && !kick) |=> ((st == ST_PH2) || (st == ST_FIRE)));

    // R8, R10: a clear of the stage-one flag outside stage one drops the interrupt
    a_r8_w1c_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == OFS_STAT) && wdata_msb && (st != ST_PH1))
        |=> !irq_pre);

endmodule

bind wdt_twophase wdt_twophase_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wdata_msb (bus_wdata[31]),
    .irq_pre   (irq_pre),
    .rst_req   (rst_req),
    .rst_kind  (rst_kind),
    .st        (fsm_state),
    .en        (cfg_en),
    .kick      (kick),
    .tcnt      (phase_cnt)
);

// File: tb/wdt_twophase_bench.sv
module wdt_twophase_bench;

    localparam int BE = 2;
    localparam logic [3:0] A_KICK = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_CTRL = 4'h8;

    typedef struct packed {
        logic [1:0] pre;
        logic [4:0] p1;
        logic [4:0] p2;
        logic [1:0] mode;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 5'd0,  5'd0,  2'd2},
        '{2'd1, 5'd3,  5'd1,  2'd0},
        '{2'd0, 5'd31, 5'd0,  2'd1},
        '{2'd3, 5'd2,  5'd4,  2'd1},
        '{2'd2, 5'd0,  5'd31, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pre;
    logic        rst_req;
    logic [1:0]  rst_kind;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdt_twophase #(.BASE_EXP(BE)) u_wdt_twophase (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pre   (irq_pre),
        .rst_req   (rst_req),
        .rst_kind  (rst_kind)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic en, input logic [1:0] pre,
                                       input logic [4:0] p1, input logic [4:0] p2,
                                       input logic [1:0] mode);
        return {en, pre, 2'b00, p1, 2'b00, p2, 13'd0, mode};
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!irq_pre);
    endtask

    task automatic wait_rst(input int start, output int n);
        n = start;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!rst_req);
    endtask

    task automatic stop_and_clear();
        logic [31:0] rd;
        bus_write(A_CTRL, 32'h0000_0001);
        bus_write(A_STAT, 32'hC000_0000);
        @(negedge clk);
        bus_read(A_STAT, rd);
        chk("R8 flags cleared", rd, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int n, m, t;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_CTRL, rd);
        chk("R1 ctrl", rd, 32'h0000_0001);
        bus_read(A_STAT, rd);
        chk("R1 stat", rd, 32'h0);
        chk("R1 outputs", {29'd0, irq_pre, rst_req, rst_kind != 2'b00}, 32'h0);

        // R9 unused control bits and read-zero offsets
        bus_write(A_CTRL, 32'h7FFF_FFFF);
        @(negedge clk);
        bus_read(A_CTRL, rd);
        chk("R9 ctrl mask", rd, 32'h67CF_8003);
        bus_read(A_KICK, rd);
        chk("R9 kick reads zero", rd, 32'h0);
        bus_read(4'hC, rd);
        chk("R9 unmapped", rd, 32'h0);
        bus_write(A_CTRL, 32'h0000_0001);

        // R2 R3 R4 R10 table of configurations
        for (int i = 0; i < NV; i++) begin
            t = 1 << (BE + int'(VEC[i].pre));
            bus_write(A_CTRL, mk(1'b1, VEC[i].pre, VEC[i].p1, VEC[i].p2, VEC[i].mode));
            wait_irq(n);
            chk("R2 stage-one edges", n, 1 + t * (int'(VEC[i].p1) + 1));
            bus_read(A_STAT, rd);
            chk("R10 stat after stage one", rd, 32'h8000_0000);
            wait_rst(0, m);
            chk("R3 stage-two edges", m, t * (int'(VEC[i].p2) + 1));
            chk("R4 kind", {30'd0, rst_kind}, {30'd0, VEC[i].mode});
            @(posedge clk);
            @(negedge clk);
            chk("R3 pulse width", {30'd0, rst_req, rst_kind != 2'b00}, 32'h0);
            bus_read(A_STAT, rd);
            chk("R3 both flags", rd, 32'hC000_0000);
            stop_and_clear();
        end

        // R5 kick in stage one, then a write without bit 31
        bus_write(A_CTRL, mk(1'b1, 2'd0, 5'd3, 5'd0, 2'd1));
        repeat (10) @(posedge clk);
        bus_write(A_KICK, 32'h8000_0000);
        repeat (6) @(posedge clk);
        bus_write(A_KICK, 32'h7FFF_FFFF);
        wait_irq(n);
        chk("R5 kick restarts stage one", n, 9);
        wait_rst(0, m);
        chk("R3 after kick", m, 4);
        @(negedge clk);
        stop_and_clear();

        // R6 disable in stage one, then a fresh start
        bus_write(A_CTRL, mk(1'b1, 2'd0, 5'd3, 5'd0, 2'd1));
        repeat (8) @(posedge clk);
        bus_write(A_CTRL, mk(1'b0, 2'd0, 5'd3, 5'd0, 2'd1));
        repeat (60) @(posedge clk);
        @(negedge clk);
        bus_read(A_STAT, rd);
        chk("R6 stopped no flag", {rd[31:30], 28'd0, irq_pre, rst_req}, 32'h0);
        bus_write(A_CTRL, mk(1'b1, 2'd0, 5'd3, 5'd0, 2'd1));
        wait_irq(n);
        chk("R6 fresh stage one", n, 17);
        wait_rst(0, m);
        chk("R6 stage two", m, 4);
        @(negedge clk);
        stop_and_clear();

        // R7 disable in stage two is ignored; R8 partial clears
        bus_write(A_CTRL, mk(1'b1, 2'd0, 5'd1, 5'd3, 2'd2));
        wait_irq(n);
        chk("R2 stage one", n, 9);
        bus_write(A_CTRL, mk(1'b0, 2'd0, 5'd1, 5'd3, 2'd2));
        wait_rst(1, m);
        chk("R7 reset still due", m, 16);
        chk("R7 kind", {30'd0, rst_kind}, 32'd2);
        @(negedge clk);
        bus_write(A_STAT, 32'h8000_0000);
        @(negedge clk);
        bus_read(A_STAT, rd);
        chk("R8 clear stage-one only", rd, 32'h4000_0000);
        chk("R10 irq low after clear", {31'd0, irq_pre}, 32'd0);
        bus_write(A_STAT, 32'h0000_0000);
        @(negedge clk);
        bus_read(A_STAT, rd);
        chk("R8 zero write keeps", rd, 32'h4000_0000);
        bus_write(A_STAT, 32'h4000_0000);
        @(negedge clk);
        bus_read(A_STAT, rd);
        chk("R8 clear stage-two", rd, 32'h0);

        // R5 kick during stage two
        bus_write(A_CTRL, mk(1'b1, 2'd0, 5'd1, 5'd1, 2'd0));
        wait_irq(n);
        bus_write(A_KICK, 32'h8000_0000);
        wait_rst(0, m);
        chk("R5 kick in stage two", m, 16);
        chk("R10 flag held", {31'd0, irq_pre}, 32'd1);
        @(negedge clk);
        stop_and_clear();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule